// File: doc/BRIEF.md
# Command-Response Buffer Control Registers

This block is the register front end of a security-module interface that passes commands and responses through a shared memory buffer. Software reaches it through a little-endian register bus that carries 1-, 2- or 4-byte accesses into a 128-byte window. Through that window software claims locality 0, moves the module between its ready and idle conditions, and rings two doorbells. The start doorbell hands a command to a processing backend. The cancel doorbell asks the backend to abandon the command it is working on. Read-only registers describe the interface's capabilities and give the size and bus address of the buffer, which begins directly after the window.

The backend side is narrow. A one-cycle start pulse carries the command length, clamped to the buffer capacity. A one-cycle cancel pulse requests an abort. A done input, qualified by an error flag, reports completion. The command tracker is a three-state machine. CS_IDLE means no command is in flight, and the start register reads 0. CS_RUN means a command has been handed over. CS_ABORT means a cancel has been signalled and completion is still awaited. The transitions are as follows. Launch takes CS_IDLE to CS_RUN on an accepted start. Abort takes CS_RUN to CS_ABORT on an accepted cancel. Finish takes CS_RUN or CS_ABORT back to CS_IDLE on done. All other events leave the state unchanged.

Top module: `crb_ctrl_regs`

## Requirements
- R1: After reset, the command size (0x58) and the response size (0x64) read 0xF80. The command address low word (0x5C) and the response address low word (0x68) read the region base plus 0x80. The words at 0x60 and 0x6C read 0.
- R2: The interface identifier reads 0x01025811 at 0x30. This value encodes type 1 in bits 3:0, version 1 in bits 7:4, transfer size 3 in bits 12:11, buffer capability in bit 14, selector 1 in bits 18:17 and revision 1 in bits 31:24. At 0x34 it reads the device ID 1 in bits 63:48 over the vendor ID parameter in bits 47:32.
- R3: A read of size code 0, 1 or 2 (1, 2 or 4 bytes) at any byte offset returns the addressed bytes little-endian and right-aligned, one cycle later, with rd_valid high. Bytes in reserved areas or beyond offset 0x7F read 0.
- R4: At the control request register (0x40), the written value is taken from the access's own bytes only. A value of 1 clears the idle bit (bit 1 of 0x44), a value of 2 sets it, and any other value leaves it unchanged. The idle bit is 0 after reset.
- R5: Writing 1 to the start register (0x4C) while its bit 0 is clear sets bit 0. The cycle after the write, it raises be_start for exactly one cycle, and be_cmd_len then holds the smaller of be_hdr_len and 0xF80.
- R6: A write of 1 to the start register while its bit 0 is set produces no start pulse and leaves bit 0 set.
- R7: Writing exactly 1 to the cancel register (0x48) pulses be_cancel for one cycle, but only while start bit 0 is set. Any other value, or any write while bit 0 is clear, produces no pulse.
- R8: be_done clears start bit 0. If be_err is high at that time, it sets the error bit (bit 0 of 0x44). The error bit stays set until the next accepted start clears it. A done that arrives while no command is in flight has no effect.
- R9: Writing 1 to locality control (0x08) sets the granted bit in locality status (0x0C bit 0) and clears the seized bit (bit 1). In locality state (0x00) it sets the assigned bit (bit 1) and the valid bit (bit 7), so that register reads 0x82.
- R10: Writes of 2 or 8 to locality control change no state. A write whose address is not exactly a register offset changes no state.
- R11: be_rsp_cap always equals 0xF80.
- R12: Reset returns the idle, error, start and locality bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset within the window |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Read data, right-aligned |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| be_start | output | 1 | Command start pulse |
| be_cmd_len | output | LEN_W | Clamped command length |
| be_rsp_cap | output | LEN_W | Response capacity |
| be_cancel | output | 1 | Cancel pulse |
| be_hdr_len | input | LEN_W | Length field from the command header |
| be_done | input | 1 | Backend completion |
| be_err | input | 1 | Completion carries an error |

## Verification
The hardest condition to reach from the ports is CS_ABORT followed by an errored completion. Reaching it requires a start accepted from idle, a cancel accepted while busy, and then a done with be_err high. The stimulus builds this sequence step by step and reads the start and status registers at each step. It then issues a second start with an oversized header length. This shows that the error bit is cleared and the length is clamped in the same cycle. Repeated start and cancel writes at the wrong moments are counted against the pulse monitors, so an extra pulse cannot hide.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int unsigned WIN_BYTES = 128;
    localparam int unsigned WIN_AW    = 7;
    localparam int unsigned WORDS     = WIN_BYTES / 4;

    localparam logic [WIN_AW-1:0] OFF_LOC_STATE = 7'h00;
    localparam logic [WIN_AW-1:0] OFF_LOC_CTRL  = 7'h08;
    localparam logic [WIN_AW-1:0] OFF_LOC_STS   = 7'h0C;
    localparam logic [WIN_AW-1:0] OFF_ID_LO     = 7'h30;
    localparam logic [WIN_AW-1:0] OFF_ID_HI     = 7'h34;
    localparam logic [WIN_AW-1:0] OFF_REQ       = 7'h40;
    localparam logic [WIN_AW-1:0] OFF_STS       = 7'h44;
    localparam logic [WIN_AW-1:0] OFF_CANCEL    = 7'h48;
    localparam logic [WIN_AW-1:0] OFF_START     = 7'h4C;
    localparam logic [WIN_AW-1:0] OFF_CMD_SZ    = 7'h58;
    localparam logic [WIN_AW-1:0] OFF_CMD_LO    = 7'h5C;
    localparam logic [WIN_AW-1:0] OFF_CMD_HI    = 7'h60;
    localparam logic [WIN_AW-1:0] OFF_RSP_SZ    = 7'h64;
    localparam logic [WIN_AW-1:0] OFF_RSP_LO    = 7'h68;
    localparam logic [WIN_AW-1:0] OFF_RSP_HI    = 7'h6C;

    localparam logic [31:0] VAL_REQ_READY = 32'd1;
    localparam logic [31:0] VAL_REQ_IDLE  = 32'd2;
    localparam logic [31:0] VAL_DOORBELL  = 32'd1;
    localparam logic [31:0] VAL_LOC_GRAB  = 32'd1;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_RUN   = 2'd1,
        CS_ABORT = 2'd2
    } cmd_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic loc_ctrl;
        logic ctrl_req;
        logic cancel;
        logic start;
    } wr_strobe_t;

    typedef struct packed {
        logic loc_valid;
        logic loc_assigned;
        logic loc_granted;
        logic idle;
        logic err;
        logic start;
    } reg_view_t;

endpackage

// File: rtl/crb_wr_decode.sv
module crb_wr_decode
    import crb_pkg::*;
(
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output wr_strobe_t        stb,
    output logic [31:0]       wval
);

    logic wr;

    assign wr = bus_req && bus_we;

    always_comb begin
        unique case (bus_size)
            SZ_BYTE: wval = {24'b0, bus_wdata[7:0]};
            SZ_HALF: wval = {16'b0, bus_wdata[15:0]};
            default: wval = bus_wdata;
        endcase
    end

    always_comb begin
        stb          = '0;
        stb.loc_ctrl = wr && (bus_addr == OFF_LOC_CTRL);
        stb.ctrl_req = wr && (bus_addr == OFF_REQ);
        stb.cancel   = wr && (bus_addr == OFF_CANCEL);
        stb.start    = wr && (bus_addr == OFF_START);
    end

endmodule

// File: rtl/crb_cmd_fsm.sv
module crb_cmd_fsm
    import crb_pkg::*;
#(
    parameter int unsigned LEN_W     = 32,
    parameter int unsigned BUF_BYTES = 3968
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_start,
    input  logic             stb_cancel,
    input  logic [31:0]      wval,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic             done,
    input  logic             err,
    output logic             start_bit,
    output logic             err_bit,
    output logic             be_start,
    output logic             be_cancel,
    output logic [LEN_W-1:0] cmd_len
);

    localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);

    cmd_state_e state_q, state_d;
    logic       start_go;
    logic       cancel_go;
    logic       finish;

    assign start_go  = stb_start && (wval == VAL_DOORBELL) && (state_q == CS_IDLE);
    assign cancel_go = stb_cancel && (wval == VAL_DOORBELL) && (state_q != CS_IDLE);
    assign finish    = done && (state_q != CS_IDLE);
    assign start_bit = (state_q != CS_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:  if (start_go) state_d = CS_RUN;
            CS_RUN: begin
                if (done)           state_d = CS_IDLE;
                else if (cancel_go) state_d = CS_ABORT;
            end
            CS_ABORT: if (done) state_d = CS_IDLE;
            default:  state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_start  <= 1'b0;
            be_cancel <= 1'b0;
            cmd_len   <= '0;
            err_bit   <= 1'b0;
        end else begin
            be_start  <= start_go;
            be_cancel <= cancel_go;
            if (start_go) begin
                cmd_len <= (hdr_len < CAP) ? hdr_len : CAP;
                err_bit <= 1'b0;
            end else if (finish && err) begin
                err_bit <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/crb_rd_mux.sv
module crb_rd_mux
    import crb_pkg::*;
#(
    parameter logic [31:0] REGION_BASE = 32'hFED4_0000,
    parameter int unsigned BUF_BYTES   = 3968,
    parameter logic [15:0] VENDOR_ID   = 16'h1014
) (
    input  reg_view_t         view,
    input  logic [WIN_AW-1:0] addr,
    input  logic [1:0]        size,
    output logic [31:0]       data
);

    localparam logic [31:0] BUF_ADDR = REGION_BASE + WIN_BYTES;
    localparam logic [31:0] BUF_SZ   = 32'(BUF_BYTES);
    localparam logic [63:0] ID_WORD  = {16'h0001, VENDOR_ID, 8'h01, 4'h0, 1'b0,
                                        2'd1, 2'b00, 1'b1, 1'b0, 2'd3, 1'b0,
                                        1'b0, 1'b0, 4'd1, 4'd1};

    logic [31:0] words [WORDS];
    logic [4:0]  idx;
    logic [5:0]  nxt;
    logic [31:0] lo_w, hi_w;
    logic [63:0] pair, shifted;

    function automatic logic [31:0] word_at(input logic [4:0] i, input reg_view_t v);
        logic [WIN_AW-1:0] off;
        off = {i, 2'b00};
        unique case (off)
            OFF_LOC_STATE: word_at = {24'b0, v.loc_valid, 5'b0, v.loc_assigned, 1'b0};
            OFF_LOC_STS:   word_at = {30'b0, 1'b0, v.loc_granted};
            OFF_ID_LO:     word_at = ID_WORD[31:0];
            OFF_ID_HI:     word_at = ID_WORD[63:32];
            OFF_STS:       word_at = {30'b0, v.idle, v.err};
            OFF_START:     word_at = {31'b0, v.start};
            OFF_CMD_SZ:    word_at = BUF_SZ;
            OFF_CMD_LO:    word_at = BUF_ADDR;
            OFF_RSP_SZ:    word_at = BUF_SZ;
            OFF_RSP_LO:    word_at = BUF_ADDR;
            default:       word_at = 32'b0;
        endcase
    endfunction

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = word_at(5'(g), view);
    end

    assign idx  = addr[WIN_AW-1:2];
    assign nxt  = {1'b0, idx} + 6'd1;
    assign lo_w = words[idx];
    assign hi_w = nxt[5] ? 32'b0 : words[nxt[4:0]];
    assign pair = {hi_w, lo_w};
    assign shifted = pair >> {addr[1:0], 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: data = {24'b0, shifted[7:0]};
            SZ_HALF: data = {16'b0, shifted[15:0]};
            default: data = shifted[31:0];
        endcase
    end

endmodule

// File: rtl/crb_ctrl_regs.sv
module crb_ctrl_regs
    import crb_pkg::*;
#(
    parameter logic [31:0] REGION_BASE  = 32'hFED4_0000,
    parameter int unsigned REGION_BYTES = 4096,
    parameter logic [15:0] VENDOR_ID    = 16'h1014,
    parameter int unsigned LEN_W        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [6:0]       bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      rd_data,
    output logic             rd_valid,
    output logic             be_start,
    output logic [LEN_W-1:0] be_cmd_len,
    output logic [LEN_W-1:0] be_rsp_cap,
    output logic             be_cancel,
    input  logic [LEN_W-1:0] be_hdr_len,
    input  logic             be_done,
    input  logic             be_err
);

    localparam int unsigned BUF_BYTES = REGION_BYTES - WIN_BYTES;

    wr_strobe_t  stb;
    logic [31:0] wval;
    logic        start_bit;
    logic        err_bit;
    logic        idle_q;
    logic        granted_q;
    logic        assigned_q;
    logic        valid_q;
    reg_view_t   view;
    logic [31:0] rd_comb;

    crb_wr_decode u_dec (
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .stb       (stb),
        .wval      (wval)
    );

    crb_cmd_fsm #(
        .LEN_W     (LEN_W),
        .BUF_BYTES (BUF_BYTES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_start  (stb.start),
        .stb_cancel (stb.cancel),
        .wval       (wval),
        .hdr_len    (be_hdr_len),
        .done       (be_done),
        .err        (be_err),
        .start_bit  (start_bit),
        .err_bit    (err_bit),
        .be_start   (be_start),
        .be_cancel  (be_cancel),
        .cmd_len    (be_cmd_len)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
        end else if (stb.ctrl_req) begin
            if (wval == VAL_REQ_READY)     idle_q <= 1'b0;
            else if (wval == VAL_REQ_IDLE) idle_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            granted_q  <= 1'b0;
            assigned_q <= 1'b0;
            valid_q    <= 1'b0;
        end else if (stb.loc_ctrl && (wval == VAL_LOC_GRAB)) begin
            granted_q  <= 1'b1;
            assigned_q <= 1'b1;
            valid_q    <= 1'b1;
        end
    end

    always_comb begin
        view              = '0;
        view.loc_valid    = valid_q;
        view.loc_assigned = assigned_q;
        view.loc_granted  = granted_q;
        view.idle         = idle_q;
        view.err          = err_bit;
        view.start        = start_bit;
    end

    crb_rd_mux #(
        .REGION_BASE (REGION_BASE),
        .BUF_BYTES   (BUF_BYTES),
        .VENDOR_ID   (VENDOR_ID)
    ) u_rd (
        .view (view),
        .addr (bus_addr),
        .size (bus_size),
        .data (rd_comb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= bus_req && !bus_we;
            if (bus_req && !bus_we) rd_data <= rd_comb;
        end
    end

    assign be_rsp_cap = LEN_W'(BUF_BYTES);

endmodule

// File: rtl/crb_ctrl_regs_chk.sv
module crb_ctrl_regs_chk #(
    parameter int unsigned LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic             rd_valid,
    input logic             be_start,
    input logic             be_cancel,
    input logic [LEN_W-1:0] be_cmd_len,
    input logic [LEN_W-1:0] be_rsp_cap,
    input logic             be_done,
    input logic             start_bit,
    input logic             err_bit
);

    assert_rd_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> rd_valid);

    assert_len_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> (be_cmd_len <= be_rsp_cap));

    assert_single_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |=> !be_start);

    assert_cancel_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        be_cancel |-> $past(start_bit));

    assert_no_mixed_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(be_start && be_cancel));

    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (be_done && start_bit) |=> !start_bit);

    assert_err_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> !err_bit);

endmodule

bind crb_ctrl_regs crb_ctrl_regs_chk #(.LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .rd_valid   (rd_valid),
    .be_start   (be_start),
    .be_cancel  (be_cancel),
    .be_cmd_len (be_cmd_len),
    .be_rsp_cap (be_rsp_cap),
    .be_done    (be_done),
    .start_bit  (start_bit),
    .err_bit    (err_bit)
);

// File: tb/crb_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module crb_ctrl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        be_start;
    logic [31:0] be_cmd_len;
    logic [31:0] be_rsp_cap;
    logic        be_cancel;
    logic [31:0] be_hdr_len = '0;
    logic        be_done = 1'b0;
    logic        be_err = 1'b0;

    int total = 0;
    int bad = 0;
    int start_cnt = 0;
    int cancel_cnt = 0;

    always #10 clk = ~clk;

    crb_ctrl_regs dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .be_start   (be_start),
        .be_cmd_len (be_cmd_len),
        .be_rsp_cap (be_rsp_cap),
        .be_cancel  (be_cancel),
        .be_hdr_len (be_hdr_len),
        .be_done    (be_done),
        .be_err     (be_err)
    );

    always @(posedge clk) begin
        if (rst_n && be_start)  start_cnt++;
        if (rst_n && be_cancel) cancel_cnt++;
    end

    typedef struct packed {
        logic [3:0]  req;
        logic [6:0]  addr;
        logic [1:0]  size;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 7'h58, 2'd2, 32'h0000_0F80},   // R1
        '{4'd1, 7'h5C, 2'd2, 32'hFED4_0080},   // R1
        '{4'd1, 7'h60, 2'd2, 32'h0000_0000},   // R1
        '{4'd1, 7'h64, 2'd2, 32'h0000_0F80},   // R1
        '{4'd1, 7'h68, 2'd2, 32'hFED4_0080},   // R1
        '{4'd1, 7'h6C, 2'd2, 32'h0000_0000},   // R1
        '{4'd2, 7'h30, 2'd2, 32'h0102_5811},   // R2
        '{4'd2, 7'h34, 2'd2, 32'h0001_1014},   // R2
        '{4'd3, 7'h31, 2'd1, 32'h0000_0258},   // R3
        '{4'd3, 7'h33, 2'd2, 32'h0110_1401},   // R3
        '{4'd3, 7'h5E, 2'd0, 32'h0000_00D4},   // R3
        '{4'd3, 7'h20, 2'd2, 32'h0000_0000},   // R3
        '{4'd3, 7'h7E, 2'd2, 32'h0000_0000},   // R3
        '{4'd3, 7'h50, 2'd2, 32'h0000_0000},   // R3
        '{4'd12, 7'h44, 2'd2, 32'h0000_0000},  // R12
        '{4'd12, 7'h4C, 2'd2, 32'h0000_0000},  // R12
        '{4'd12, 7'h0C, 2'd2, 32'h0000_0000}   // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = s;
        @(negedge clk);
        d = rd_valid ? rd_data : 32'hDEAD_BEEF;
        bus_req = 1'b0;
    endtask

    task automatic pulse_done(input logic e);
        @(negedge clk);
        be_done = 1'b1; be_err = e;
        @(negedge clk);
        be_done = 1'b0; be_err = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus_read(VEC[i].addr, VEC[i].size, r);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
        end

        check("R11 rsp cap", be_rsp_cap, 32'h0000_0F80);

        // R4 ready/idle handshake
        bus_write(7'h40, 2'd2, 32'd2);
        bus_read(7'h44, 2'd2, r); check("R4 idle set", r, 32'h2);
        bus_write(7'h40, 2'd2, 32'd3);
        bus_read(7'h44, 2'd2, r); check("R4 other value ignored", r, 32'h2);
        bus_write(7'h40, 2'd2, 32'd1);
        bus_read(7'h44, 2'd2, r); check("R4 idle cleared", r, 32'h0);
        bus_write(7'h40, 2'd0, 32'hFFFF_FF02);
        bus_read(7'h44, 2'd2, r); check("R4 byte write masked", r, 32'h2);
        bus_write(7'h40, 2'd2, 32'h0000_0102);
        bus_read(7'h44, 2'd2, r); check("R4 wide value ignored", r, 32'h2);

        // R10 locality no-op writes and unaligned writes
        bus_write(7'h08, 2'd2, 32'd2);
        bus_write(7'h08, 2'd2, 32'd8);
        bus_write(7'h09, 2'd0, 32'd1);
        bus_read(7'h0C, 2'd2, r); check("R10 locality status untouched", r, 32'h0);
        bus_read(7'h00, 2'd2, r); check("R10 locality state untouched", r, 32'h0);

        // R9 locality request
        bus_write(7'h08, 2'd2, 32'd1);
        bus_read(7'h0C, 2'd2, r); check("R9 granted", r, 32'h1);
        bus_read(7'h00, 2'd2, r); check("R9 state bits", r, 32'h82);
        bus_read(7'h00, 2'd0, r); check("R9 state byte", r, 32'h82);

        // R7 cancel while idle: no pulse
        bus_write(7'h48, 2'd2, 32'd1);
        check("R7 cancel while idle", 32'(cancel_cnt), 32'd0);

        // R5 start accepted
        be_hdr_len = 32'h123;
        bus_write(7'h4C, 2'd2, 32'd1);
        check("R5 start pulse", {31'b0, be_start}, 32'd1);
        check("R5 cmd len", be_cmd_len, 32'h123);
        bus_read(7'h4C, 2'd2, r); check("R5 start bit set", r, 32'h1);
        check("R5 one pulse", 32'(start_cnt), 32'd1);

        // R6 second start ignored
        bus_write(7'h4C, 2'd2, 32'd1);
        bus_read(7'h4C, 2'd2, r); check("R6 still busy", r, 32'h1);
        check("R6 no extra pulse", 32'(start_cnt), 32'd1);

        // R7 cancel while busy
        bus_write(7'h48, 2'd2, 32'd3);
        check("R7 wrong value no cancel", 32'(cancel_cnt), 32'd0);
        bus_write(7'h48, 2'd2, 32'd1);
        check("R7 cancel pulse", {31'b0, be_cancel}, 32'd1);
        @(negedge clk);
        check("R7 one cancel", 32'(cancel_cnt), 32'd1);
        bus_read(7'h4C, 2'd2, r); check("R7 start held during abort", r, 32'h1);

        // R8 errored completion from the abort state
        pulse_done(1'b1);
        bus_read(7'h4C, 2'd2, r); check("R8 start cleared", r, 32'h0);
        bus_read(7'h44, 2'd2, r); check("R8 error set", r, 32'h3);

        // R8 stray done has no effect
        pulse_done(1'b0);
        bus_read(7'h44, 2'd2, r); check("R8 stray done", r, 32'h3);

        // R5 clamp and R8 error cleared by start
        be_hdr_len = 32'h5000;
        bus_write(7'h4C, 2'd2, 32'd1);
        check("R5 clamp", be_cmd_len, 32'h0F80);
        bus_read(7'h44, 2'd2, r); check("R8 error cleared on start", r, 32'h2);
        check("R5 second pulse", 32'(start_cnt), 32'd2);
        pulse_done(1'b0);
        bus_read(7'h44, 2'd2, r); check("R8 clean done", r, 32'h2);
        bus_read(7'h4C, 2'd2, r); check("R8 start cleared clean", r, 32'h0);

        // R12 reset in mid state
        be_hdr_len = 32'h10;
        bus_write(7'h4C, 2'd2, 32'd1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        bus_read(7'h4C, 2'd2, r); check("R12 start reset", r, 32'h0);
        bus_read(7'h44, 2'd2, r); check("R12 status reset", r, 32'h0);
        bus_read(7'h00, 2'd2, r); check("R12 locality reset", r, 32'h0);
        bus_read(7'h58, 2'd2, r); check("R1 size after reset", r, 32'h0F80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule